// File: doc/BRIEF.md
# Decimation Conversion Timing Sequencer

This block decides when a conversion of a sigma-delta decimation path is complete. It counts ticks on a one-cycle tick input, which marks either an edge of the modulator bit clock or the arrival of a parallel sample. When the settling time for the selected filter kind, filter order, filter oversampling ratio and integrator oversampling ratio has passed, it raises a one-cycle done pulse. The sinc arithmetic, any threshold watchdog and the register bus are outside this block.

A conversion starts on a start pulse while the block is enabled and idle. In continuous mode a new conversion starts at the end of each one, with no idle tick in between. An optional fast setting shortens every continuous conversion after the first. A filter oversampling ratio of one selects a bypass mode where only the integrator runs. The regular channel number is captured at the start of each conversion, so a change made mid-conversion applies from the next conversion. Every pin is a plain control or status signal. No data words pass through the block, so there is no valid/ready handshake and no back-pressure.

Top module: `cnv_timing_seq`

## Requirements
- R1: After reset `busy_o`, `done_o` and `ch_o` are all 0.
- R2: A start is accepted only when `start_i` and `en_i` are both high and `busy_o` is low. `busy_o` is high in the cycle after acceptance, and `ch_o` then shows the `chsel_i` value present at acceptance. A start while `en_i` is low is ignored.
- R3: The fields `fosr_m1_i` and `iosr_m1_i` hold each ratio minus one, so F = `fosr_m1_i`+1 and I = `iosr_m1_i`+1. With `ftype_i`=0 (sinc), F>1 and order N on `ord_i` (1 to 5), a standard conversion ends after F*(I-1+N)+N counted ticks. `done_o` is high in the cycle after the clock edge that samples the last counted tick.
- R4: With `ftype_i`=1 (fast-sinc) and F>1, a standard conversion ends after F*(I+3)+2 counted ticks, and `ord_i` is ignored.
- R5: With `fosr_m1_i`=0 (filter bypassed), every conversion ends after I counted ticks, whatever the values of `ftype_i`, `ord_i` and the fast setting.
- R6: With `cont_i` high when a conversion ends, `busy_o` stays high and the next conversion counts from the very next tick. With `cont_i` low at the end, `busy_o` goes low in the same cycle that `done_o` is high.
- R7: With the fast setting on and continuous mode, the first conversion has the standard length, and every later conversion lasts F*I ticks.
- R8: The fast setting has no effect on a single (non-continuous) conversion.
- R9: `fast_i` is captured only while `en_i` is low. While `en_i` is high the captured setting keeps its value.
- R10: A `chsel_i` change during a conversion leaves `ch_o` unchanged until the next conversion starts, including a continuous restart.
- R11: A start pulse while `busy_o` is high changes neither the remaining length nor `ch_o`.
- R12: Driving `en_i` low aborts a conversion. `busy_o` is low in the next cycle, and no `done_o` follows.
- R13: `done_o` is high for exactly one cycle for each finished conversion.
- R14: Only cycles with `tick_i` high advance the count. Idle cycles between ticks do not change the length measured in ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Filter enable. Low aborts the conversion and unlocks the fast setting |
| start_i | input | 1 | Start request pulse |
| cont_i | input | 1 | Continuous mode |
| fast_i | input | 1 | Fast continuous setting, captured while disabled |
| ftype_i | input | 1 | Filter kind: 0 sinc, 1 fast-sinc |
| ord_i | input | 3 | Sinc order, 1 to 5 |
| fosr_m1_i | input | FOSR_W | Filter oversampling ratio minus one |
| iosr_m1_i | input | IOSR_W | Integrator oversampling ratio minus one |
| chsel_i | input | CH_W | Requested regular channel |
| tick_i | input | 1 | One-cycle input tick (bit clock edge or data strobe) |
| busy_o | output | 1 | Conversion sequence active |
| done_o | output | 1 | One-cycle conversion-done pulse |
| ch_o | output | CH_W | Channel of the current conversion |

## Verification
The assertions assume that `ord_i` stays within 1 to 5 whenever a conversion length is loaded, so that every loaded length is nonzero. They also assume that `start_i` and `tick_i` are synchronous single-cycle strobes. The stimulus changes configuration only between conversions, or at the points where a test deliberately probes deferral. It uses only legal orders, and it never drives a tick in the same cycle as a start. The channel and fast-setting properties rely only on the enable and load conditions, so any stimulus on `chsel_i` and `fast_i` stays within them.

// File: rtl/cnv_seq_pkg.sv
package cnv_seq_pkg;
  typedef enum logic {
    FT_SINC     = 1'b0,
    FT_FASTSINC = 1'b1
  } flt_kind_e;

  // fast-sinc behaves like an order-4 path with a short tail
  localparam int FASTSINC_ORD  = 4;
  localparam int FASTSINC_TAIL = 2;
endpackage

// File: rtl/cnv_len_calc.sv
module cnv_len_calc
  import cnv_seq_pkg::*;
#(
  parameter int FOSR_W = 10,
  parameter int IOSR_W = 8,
  parameter int ORD_W  = 3,
  parameter int LEN_W  = FOSR_W + IOSR_W + 2
) (
  input  logic [FOSR_W-1:0] fosr_m1_i,
  input  logic [IOSR_W-1:0] iosr_m1_i,
  input  logic [ORD_W-1:0]  ord_i,
  input  flt_kind_e         kind_i,
  input  logic              fast_sel_i,
  output logic [LEN_W-1:0]  len_o
);
  logic [LEN_W-1:0] f_r, i_r, o_r;

  assign f_r = LEN_W'(fosr_m1_i) + LEN_W'(1);
  assign i_r = LEN_W'(iosr_m1_i) + LEN_W'(1);
  assign o_r = LEN_W'(ord_i);

  always_comb begin
    if (fosr_m1_i == '0)
      len_o = i_r;                                   // integrator only
    else if (fast_sel_i)
      len_o = f_r * i_r;                             // steady continuous
    else if (kind_i == FT_FASTSINC)
      len_o = f_r * (i_r + LEN_W'(FASTSINC_ORD - 1)) + LEN_W'(FASTSINC_TAIL);
    else
      len_o = f_r * (i_r - LEN_W'(1) + o_r) + o_r;
  end
endmodule

// File: rtl/cnv_tick_ctr.sv
module cnv_tick_ctr #(
  parameter int LEN_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             active_i,
  input  logic             tick_i,
  output logic             last_o
);
  logic [LEN_W-1:0] rem_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rem_q <= '0;
    else if (load_i)
      rem_q <= len_i;
    else if (active_i && tick_i && rem_q != '0)
      rem_q <= rem_q - LEN_W'(1);
  end

  assign last_o = (rem_q == LEN_W'(1));

  // R3: a running conversion always has ticks left to count
  p_rem_live_r3: assert property (@(posedge clk) disable iff (!rst_n)
    active_i |-> rem_q != '0);
endmodule

// File: rtl/cnv_cfg_latch.sv
module cnv_cfg_latch #(
  parameter int CH_W = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en_i,
  input  logic            fast_i,
  input  logic            load_i,
  input  logic [CH_W-1:0] chsel_i,
  output logic            fast_o,
  output logic [CH_W-1:0] ch_o
);
  logic            fast_q;
  logic [CH_W-1:0] ch_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fast_q <= 1'b0;
      ch_q   <= '0;
    end else begin
      if (!en_i)  fast_q <= fast_i;
      if (load_i) ch_q   <= chsel_i;
    end
  end

  assign fast_o = fast_q;
  assign ch_o   = ch_q;

  p_fast_locked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    en_i |=> $stable(fast_q));

  p_ch_deferred_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> $stable(ch_q));
endmodule

// File: rtl/cnv_timing_seq.sv
module cnv_timing_seq
  import cnv_seq_pkg::*;
#(
  parameter int FOSR_W = 10,
  parameter int IOSR_W = 8,
  parameter int CH_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic              start_i,
  input  logic              cont_i,
  input  logic              fast_i,
  input  logic              ftype_i,
  input  logic [2:0]        ord_i,
  input  logic [FOSR_W-1:0] fosr_m1_i,
  input  logic [IOSR_W-1:0] iosr_m1_i,
  input  logic [CH_W-1:0]   chsel_i,
  input  logic              tick_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [CH_W-1:0]   ch_o
);
  localparam int ORD_W = 3;
  localparam int LEN_W = FOSR_W + IOSR_W + 2;

  logic             busy_q, done_q;
  logic             fast_q, last;
  logic             accept, conv_end, reload, load;
  logic [LEN_W-1:0] len;

  assign accept   = en_i && start_i && !busy_q;
  assign conv_end = en_i && busy_q && tick_i && last;
  assign reload   = conv_end && cont_i;
  assign load     = accept || reload;

  cnv_len_calc #(
    .FOSR_W(FOSR_W), .IOSR_W(IOSR_W), .ORD_W(ORD_W), .LEN_W(LEN_W)
  ) u_len (
    .fosr_m1_i (fosr_m1_i),
    .iosr_m1_i (iosr_m1_i),
    .ord_i     (ord_i),
    .kind_i    (flt_kind_e'(ftype_i)),
    .fast_sel_i(busy_q && fast_q),   // only a restart can be a fast one
    .len_o     (len)
  );

  cnv_tick_ctr #(.LEN_W(LEN_W)) u_ctr (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (load),
    .len_i   (len),
    .active_i(busy_q && en_i),
    .tick_i  (tick_i),
    .last_o  (last)
  );

  cnv_cfg_latch #(.CH_W(CH_W)) u_cfg (
    .clk    (clk),
    .rst_n  (rst_n),
    .en_i   (en_i),
    .fast_i (fast_i),
    .load_i (load),
    .chsel_i(chsel_i),
    .fast_o (fast_q),
    .ch_o   (ch_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= conv_end;
      if (!en_i)
        busy_q <= 1'b0;
      else if (accept)
        busy_q <= 1'b1;
      else if (conv_end && !cont_i)
        busy_q <= 1'b0;
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;

  p_busy_from_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(start_i && en_i));

  p_abort_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> !busy_o && !done_o);

  p_done_on_tick_r14: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(tick_i && busy_o));

  p_stop_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !busy_o) |-> $past(!cont_i));
endmodule

// File: tb/cnv_timing_seq_tb.sv
`timescale 1ns/1ps
module cnv_timing_seq_tb;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n, en_i, start_i, cont_i, fast_i, ftype_i, tick_i;
  logic [2:0] ord_i;
  logic [9:0] fosr_m1_i;
  logic [7:0] iosr_m1_i;
  logic [1:0] chsel_i;
  logic       busy_o, done_o;
  logic [1:0] ch_o;

  int n_chk = 0;
  int n_bad = 0;

  cnv_timing_seq u_dut (
    .clk(clk), .rst_n(rst_n), .en_i(en_i), .start_i(start_i), .cont_i(cont_i),
    .fast_i(fast_i), .ftype_i(ftype_i), .ord_i(ord_i), .fosr_m1_i(fosr_m1_i),
    .iosr_m1_i(iosr_m1_i), .chsel_i(chsel_i), .tick_i(tick_i),
    .busy_o(busy_o), .done_o(done_o), .ch_o(ch_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
  endtask

  // Called at a negedge: issue ticks (with idle gaps) until done_o shows up.
  task automatic measure(input int exp, input int gap, input string req);
    int  cnt    = 0;
    int  stray  = 0;
    bit  seen   = 0;
    while (!seen && cnt < 4000) begin
      tick_i = 1'b1;
      @(negedge clk);
      tick_i = 1'b0;
      cnt++;
      if (done_o) seen = 1;
      else for (int g = 0; g < gap; g++) begin
        @(negedge clk);
        if (done_o) stray++;
      end
    end
    chk(cnt == exp, req, "ticks to done", cnt, exp);
    if (gap > 0) chk(stray == 0, "R14", "done on idle cycle", stray, 0);
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) begin
      tick_i = 1'b1; @(negedge clk); tick_i = 1'b0;
    end
  endtask

  task automatic kick(input logic [1:0] ch);
    chsel_i = ch; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(busy_o == 1'b1, "R2", "busy after start", busy_o, 1);
    chk(ch_o == ch, "R2", "channel at start", ch_o, ch);
  endtask

  task automatic cfg(input logic ft, input int ord, input int fm1, input int im1);
    ftype_i = ft; ord_i = 3'(ord); fosr_m1_i = 10'(fm1); iosr_m1_i = 8'(im1);
  endtask

  task automatic set_fast(input logic v);
    en_i = 1'b0; fast_i = v; @(negedge clk); en_i = 1'b1; @(negedge clk);
  endtask

  task automatic end_single(input string req);
    chk(busy_o == 1'b0, req, "busy with final done", busy_o, 0);
    @(negedge clk);
    chk(done_o == 1'b0, "R13", "done width", done_o, 0);
  endtask

  task automatic t_reset();
    chk(busy_o == 0, "R1", "busy", busy_o, 0);
    chk(done_o == 0, "R1", "done", done_o, 0);
    chk(ch_o == 0, "R1", "ch", ch_o, 0);
  endtask

  task automatic t_start_gate();
    en_i = 1'b0; chsel_i = 2'd3; start_i = 1'b1; @(negedge clk);
    start_i = 1'b0; @(negedge clk);
    chk(busy_o == 0, "R2", "start while disabled", busy_o, 0);
    chk(ch_o == 0, "R2", "ch while disabled", ch_o, 0);
    en_i = 1'b1; @(negedge clk);
  endtask

  task automatic t_sinc();
    cont_i = 0;
    cfg(0, 3, 3, 1); kick(2'd1); measure(19, 0, "R3"); end_single("R3");
    cfg(0, 1, 1, 2); kick(2'd2); measure(7, 2, "R3"); end_single("R3");
    cfg(0, 5, 2, 0); kick(2'd0); measure(20, 1, "R14"); end_single("R3");
  endtask

  task automatic t_fastsinc();
    cfg(1, 1, 2, 1); kick(2'd1); measure(17, 0, "R4"); end_single("R4");
  endtask

  task automatic t_bypass();
    cfg(0, 3, 0, 4); kick(2'd0); measure(5, 0, "R5"); end_single("R5");
    cfg(1, 3, 0, 4); kick(2'd0); measure(5, 1, "R5"); end_single("R5");
  endtask

  task automatic t_single_fast();
    set_fast(1); cont_i = 0;
    cfg(0, 2, 1, 1); kick(2'd3); measure(8, 0, "R8"); end_single("R8");
    set_fast(0);
  endtask

  task automatic t_cont();
    cont_i = 1; cfg(0, 2, 1, 2);
    kick(2'd0); measure(10, 0, "R6");
    chk(busy_o == 1, "R6", "busy across restart", busy_o, 1);
    measure(10, 0, "R6");
    cont_i = 0;
    measure(10, 0, "R6"); end_single("R6");
  endtask

  task automatic t_fast_cont();
    set_fast(1); cont_i = 1; cfg(0, 2, 1, 2);
    kick(2'd1); measure(10, 0, "R7");
    measure(6, 0, "R7"); measure(6, 1, "R7");
    cont_i = 0; measure(6, 0, "R7"); end_single("R7");
  endtask

  task automatic t_fast_lock();
    fast_i = 1'b0; @(negedge clk);             // still enabled: ignored
    cont_i = 1; cfg(0, 2, 1, 2);
    kick(2'd0); measure(10, 0, "R9"); measure(6, 0, "R9");
    cont_i = 0; measure(6, 0, "R9"); end_single("R9");
    set_fast(0);
  endtask

  task automatic t_channel();
    cont_i = 1; cfg(0, 2, 1, 2);
    kick(2'd2); ticks(3); chsel_i = 2'd1; @(negedge clk);
    chk(ch_o == 2, "R10", "ch held mid-conversion", ch_o, 2);
    measure(7, 0, "R10");
    chk(ch_o == 1, "R10", "ch at restart", ch_o, 1);
    cont_i = 0; measure(10, 0, "R10"); end_single("R10");
  endtask

  task automatic t_start_busy();
    cont_i = 0; cfg(0, 2, 1, 2);
    kick(2'd3); ticks(4);
    chsel_i = 2'd0; start_i = 1'b1; @(negedge clk); start_i = 1'b0;
    chk(ch_o == 3, "R11", "ch after busy start", ch_o, 3);
    measure(6, 0, "R11"); end_single("R11");
  endtask

  task automatic t_abort();
    int dn = 0;
    cont_i = 1; cfg(0, 2, 1, 2);
    kick(2'd1); ticks(5); en_i = 1'b0; @(negedge clk);
    chk(busy_o == 0, "R12", "busy after disable", busy_o, 0);
    for (int k = 0; k < 20; k++) begin
      tick_i = 1'b1; @(negedge clk); tick_i = 1'b0;
      if (done_o) dn++;
    end
    chk(dn == 0, "R12", "done after abort", dn, 0);
    en_i = 1'b1; cont_i = 0; @(negedge clk);
    kick(2'd2); measure(10, 0, "R12"); end_single("R12");
  endtask

  initial begin
    rst_n = 0; en_i = 0; start_i = 0; cont_i = 0; fast_i = 0; ftype_i = 0;
    tick_i = 0; ord_i = 3'd1; fosr_m1_i = '0; iosr_m1_i = '0; chsel_i = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1; @(negedge clk);
    t_reset();
    t_start_gate();
    t_sinc();
    t_fastsinc();
    t_bypass();
    t_single_fast();
    t_cont();
    t_fast_cont();
    set_fast(1);
    t_fast_lock();
    t_channel();
    t_start_busy();
    t_abort();
    summary();
    $finish;
  end

  initial begin
    #1_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual 1 expected 0");
    summary();
    $finish;
  end
endmodule